// File: doc/BRIEF.md
# UART interrupt and status controller

This block gathers everything a UART driver needs to decide why it was interrupted. It compares the receive and transmit FIFO fill counts against programmable watermarks and holds a receive timeout, which gives two level status bits. It latches receiver error pulses and changes on the modem lines into sticky event bits, which software clears by writing ones. Live line levels are reported beside them.

An enable word masks the eight event and level bits, and a single registered interrupt line is raised whenever any masked bit is set. The block also drives the request-to-send output. That output follows a software bit, or it follows the receive FIFO fill level when hardware flow control is selected. All registers sit behind a small word-addressed bus with registered read data. The serial shift engines and the FIFO storage live elsewhere and feed this block through plain count and pulse inputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Status bit 0 is set while the rx count exceeds the rx watermark. An rx timeout pulse also sets it and keeps it set until the rx count reads zero; it clears itself once neither condition holds.
- R2: Status bit 1 is set while the tx count is strictly below the tx watermark, and clears once the count reaches the watermark.
- R3: One-cycle pulses latch sticky status bits at fixed positions: parity error at bit 2, framing error at bit 3, rx overrun at bit 4, DSR change at bit 5, CTS change at bit 6, break at bit 7.
- R4: A write to the clear register (address 2) clears each sticky bit whose data bit is 1. Data bits that are 0 leave the sticky bits alone, and bits 0 and 1 are never affected.
- R5: The enable register (address 1, bits 7:0) reads back as written. The masked status register (address 3) reads as status bits 7:0 AND enable. The raw status register is at address 0.
- R6: The irq output, registered, is the OR of all masked status bits. It is 0 whenever the enable word is 0.
- R7: Raw status bits 8 to 12 show the live levels of DSR, CTS, the RTS output, the RXD input and the TXD output, in that order.
- R8: CTS, DSR and RXD each pass through a two-flop synchronizer. A rising or falling edge of synchronized CTS or DSR sets its change bit.
- R9: The control register (address 4) holds a software RTS bit in bit 0 and a flow-control enable in bit 1. With bit 1 clear, rts_out follows bit 0. With bit 1 set, rts_out is 1 while rx count < rx watermark and 0 otherwise, and bit 0 is ignored.
- R10: When a sticky event and a clear write to the same bit fall in one cycle, the bit ends up set.
- R11: After the synchronous reset, all status, enable and control state reads 0, and irq and rts_out are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_wmark | input | CNT_W | Receive watermark |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| tx_wmark | input | CNT_W | Transmit watermark |
| rx_timeout | input | 1 | Receive timeout pulse |
| err_parity | input | 1 | Parity error pulse |
| err_frame | input | 1 | Framing error pulse |
| err_overrun | input | 1 | Receive overrun pulse |
| err_break | input | 1 | Break detected pulse |
| cts_in | input | 1 | Asynchronous CTS line |
| dsr_in | input | 1 | Asynchronous DSR line |
| rxd_in | input | 1 | Asynchronous serial input level |
| txd_lvl | input | 1 | Current serial output level |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rts_out | output | 1 | Request-to-send output |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the watermark boundaries: count equal to the watermark, and both values zero. A design using >= or <= in place of the strict comparisons would set bits 0 or 1 at those points. It covers the timeout hold, which a level-only design would lose one cycle after the pulse, and clear writes with zero bits or hitting level bits, which a design with a plain register write would wrongly alter. It also drives an event and its clear in the same cycle, where a clear-priority design would drop the event. Falling modem edges are checked too, since a rise-only detector would miss them, and flow-control mode is checked with the software RTS bit set opposite to the expected output.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    ADR_RAW  = 3'd0,
    ADR_EN   = 3'd1,
    ADR_CLR  = 3'd2,
    ADR_MASK = 3'd3,
    ADR_CTRL = 3'd4
  } reg_addr_e;

  localparam int NUM_STICKY = 6;   // bits 7..2
  localparam int NUM_EVT    = 8;   // bits 7..0
  localparam int NUM_LVL    = 5;   // bits 12..8
  localparam int RAW_W      = NUM_EVT + NUM_LVL;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] chg
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q[i]   <= 1'b0;
        s2_q[i]   <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        s1_q[i]   <= line_in[i];
        s2_q[i]   <= s1_q[i];
        prev_q[i] <= s2_q[i];
      end
    end
    assign chg[i] = s2_q[i] ^ prev_q[i];
  end

  assign lvl = s2_q;
endmodule

// File: rtl/irq_sticky_bits.sv
module irq_sticky_bits #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= ev | (q & ~clr);
  end

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((q & ~clr) != '0) |=> (($past(q) & ~$past(clr) & ~q) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> (($past(ev) & ~q) == '0));
endmodule

// File: rtl/irq_rts_ctrl.sv
module irq_rts_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_en,
  input  logic             sw_rts,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_wmark,
  output logic             rts
);
  always_ff @(posedge clk) begin
    if (rst)        rts <= 1'b0;
    else if (hw_en) rts <= (rx_count < rx_wmark);
    else            rts <= sw_rts;
  end

  // R9
  rts_hw_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_en && (rx_count >= rx_wmark)) |=> !rts);

  // R9
  rts_sw_chk: assert property (@(posedge clk) disable iff (rst)
    (!hw_en) |=> (rts == $past(sw_rts)));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  rx_wmark,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  tx_wmark,
  input  logic              rx_timeout,
  input  logic              err_parity,
  input  logic              err_frame,
  input  logic              err_overrun,
  input  logic              err_break,
  input  logic              cts_in,
  input  logic              dsr_in,
  input  logic              rxd_in,
  input  logic              txd_lvl,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rts_out,
  output logic              irq
);
  localparam int PAD_W = DATA_W - RAW_W;

  // modem and serial-in synchronization: index 0 dsr, 1 cts, 2 rxd
  logic [2:0] line_lvl, line_chg;
  irq_line_sync #(.N(3)) u_sync (
    .clk(clk), .rst(rst),
    .line_in({rxd_in, cts_in, dsr_in}),
    .lvl(line_lvl), .chg(line_chg)
  );

  // bus decode
  logic wr_en, wr_clr, wr_ctrl;
  assign wr_en   = bus_sel && bus_wr && (bus_addr == ADR_EN);
  assign wr_clr  = bus_sel && bus_wr && (bus_addr == ADR_CLR);
  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADR_CTRL);

  // sticky bits 7..2
  logic [NUM_STICKY-1:0] stk_ev, stk_clr, stk_q;
  assign stk_ev  = {err_break, line_chg[1], line_chg[0], err_overrun, err_frame, err_parity};
  assign stk_clr = wr_clr ? bus_wdata[7:2] : '0;

  irq_sticky_bits #(.W(NUM_STICKY)) u_sticky (
    .clk(clk), .rst(rst), .ev(stk_ev), .clr(stk_clr), .q(stk_q)
  );

  // level bits 1..0 with timeout hold
  logic to_q, to_next, rx_lvl_q, tx_lvl_q;
  assign to_next = rx_timeout | (to_q & (rx_count != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      to_q     <= 1'b0;
      rx_lvl_q <= 1'b0;
      tx_lvl_q <= 1'b0;
    end else begin
      to_q     <= to_next;
      rx_lvl_q <= (rx_count > rx_wmark) | to_next;
      tx_lvl_q <= (tx_count < tx_wmark);
    end
  end

  // control and enable registers
  logic [NUM_EVT-1:0] en_q;
  logic [1:0]         ctrl_q;
  logic               unused_wdata;
  assign unused_wdata = ^bus_wdata[7:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_en)   en_q   <= bus_wdata;
      if (wr_ctrl) ctrl_q <= bus_wdata[1:0];
    end
  end

  irq_rts_ctrl #(.CNT_W(CNT_W)) u_rts (
    .clk(clk), .rst(rst),
    .hw_en(ctrl_q[1]), .sw_rts(ctrl_q[0]),
    .rx_count(rx_count), .rx_wmark(rx_wmark),
    .rts(rts_out)
  );

  // live levels: txd, rxd, rts, cts, dsr
  logic [NUM_LVL-1:0] lvl_q;
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= {txd_lvl, line_lvl[2], rts_out, line_lvl[1], line_lvl[0]};
  end

  logic [NUM_EVT-1:0] evt_word, masked;
  assign evt_word = {stk_q, tx_lvl_q, rx_lvl_q};
  assign masked   = evt_word & en_q;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |masked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      case (bus_addr)
        ADR_RAW:  bus_rdata <= {{PAD_W{1'b0}}, lvl_q, evt_word};
        ADR_EN:   bus_rdata <= {{(DATA_W-NUM_EVT){1'b0}}, en_q};
        ADR_MASK: bus_rdata <= {{(DATA_W-NUM_EVT){1'b0}}, masked};
        ADR_CTRL: bus_rdata <= {{(DATA_W-2){1'b0}}, ctrl_q};
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq);

  // R1
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rx_timeout |=> rx_lvl_q);

  // R2
  tx_level_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_count < tx_wmark) |=> tx_lvl_q);
endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  localparam int CNT_W  = 5;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0] rx_count = '0, rx_wmark = '0, tx_count = '0, tx_wmark = '0;
  logic rx_timeout = 0, err_parity = 0, err_frame = 0, err_overrun = 0, err_break = 0;
  logic cts_in = 0, dsr_in = 0, rxd_in = 0, txd_lvl = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic rts_out, irq;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_uart_irq_ctrl (
    .clk(clk), .rst(rst),
    .rx_count(rx_count), .rx_wmark(rx_wmark), .tx_count(tx_count), .tx_wmark(tx_wmark),
    .rx_timeout(rx_timeout), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .err_break(err_break),
    .cts_in(cts_in), .dsr_in(dsr_in), .rxd_in(rxd_in), .txd_lvl(txd_lvl),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rts_out(rts_out), .irq(irq)
  );

  // {rx_count, rx_wmark, tx_count, tx_wmark, expected bit1, expected bit0}
  localparam logic [4*CNT_W+1:0] VEC [8] = '{
    {5'd3,  5'd2,  5'd1,  5'd4,  2'b11},
    {5'd2,  5'd2,  5'd4,  5'd4,  2'b00},
    {5'd0,  5'd0,  5'd0,  5'd0,  2'b00},
    {5'd16, 5'd15, 5'd15, 5'd16, 2'b11},
    {5'd5,  5'd8,  5'd9,  5'd8,  2'b00},
    {5'd1,  5'd0,  5'd0,  5'd1,  2'b11},
    {5'd4,  5'd3,  5'd5,  5'd5,  2'b01},
    {5'd0,  5'd1,  5'd2,  5'd3,  2'b10}
  };

  task automatic chk(input string tag, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
  endtask

  task automatic bwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [DATA_W-1:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    v = bus_rdata;
  endtask

  task automatic pulse_parity(); @(negedge clk); err_parity = 1; @(negedge clk); err_parity = 0; endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    logic [1:0] e;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    settle();

    // R11 reset state
    brd(3'd0, v); chk("R11 raw after reset", v, 16'h0000);
    brd(3'd1, v); chk("R11 enable after reset", v, 16'h0000);
    brd(3'd4, v); chk("R11 control after reset", v, 16'h0000);
    chk("R11 irq after reset", {15'd0, irq}, 16'd0);
    chk("R11 rts after reset", {15'd0, rts_out}, 16'd0);

    // R1 R2 watermark table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {rx_count, rx_wmark, tx_count, tx_wmark, e} = VEC[i];
      settle();
      brd(3'd0, v);
      chk($sformatf("R1 R2 vector %0d", i), {14'd0, v[1:0]}, {14'd0, e});
    end
    @(negedge clk); rx_count = 0; rx_wmark = 0; tx_count = 0; tx_wmark = 0;

    // R1 timeout hold until fifo empty
    @(negedge clk); rx_count = 2; rx_wmark = 4;
    @(negedge clk); rx_timeout = 1; @(negedge clk); rx_timeout = 0;
    settle(); brd(3'd0, v); chk("R1 timeout held", v, 16'h0001);
    @(negedge clk); rx_count = 0;
    settle(); brd(3'd0, v); chk("R1 timeout released on empty", v, 16'h0000);

    // R3 sticky error positions
    pulse_parity();
    @(negedge clk); err_frame = 1;   @(negedge clk); err_frame = 0;
    @(negedge clk); err_overrun = 1; @(negedge clk); err_overrun = 0;
    @(negedge clk); err_break = 1;   @(negedge clk); err_break = 0;
    settle(); brd(3'd0, v); chk("R3 error positions", v, 16'h009C);

    // R4 write-one-to-clear
    bwr(3'd2, 8'h00); settle(); brd(3'd0, v); chk("R4 zero clear no effect", v, 16'h009C);
    bwr(3'd2, 8'h04); settle(); brd(3'd0, v); chk("R4 clear parity only", v, 16'h0098);
    @(negedge clk); rx_count = 3; rx_wmark = 1;
    bwr(3'd2, 8'hFF); settle(); brd(3'd0, v); chk("R4 clear keeps level bit", v, 16'h0001);
    @(negedge clk); rx_count = 0; rx_wmark = 0;

    // R5 R6 enable, mask, irq
    pulse_parity();
    bwr(3'd1, 8'h0C); settle();
    brd(3'd1, v); chk("R5 enable readback", v, 16'h000C);
    brd(3'd3, v); chk("R5 masked status", v, 16'h0004);
    chk("R6 irq asserted", {15'd0, irq}, 16'd1);
    bwr(3'd1, 8'h08); settle();
    brd(3'd3, v); chk("R5 masked off", v, 16'h0000);
    chk("R6 irq deasserted", {15'd0, irq}, 16'd0);
    bwr(3'd1, 8'h00); bwr(3'd2, 8'h04);

    // R7 R8 modem lines
    @(negedge clk); cts_in = 1; settle();
    brd(3'd0, v); chk("R8 cts rise", v, 16'h0240);
    bwr(3'd2, 8'h40);
    @(negedge clk); dsr_in = 1; settle();
    brd(3'd0, v); chk("R8 dsr rise", v, 16'h0320);
    bwr(3'd2, 8'h20);
    @(negedge clk); cts_in = 0; settle();
    brd(3'd0, v); chk("R8 cts fall", v, 16'h0140);
    bwr(3'd2, 8'h40);
    @(negedge clk); rxd_in = 1; txd_lvl = 1; settle();
    brd(3'd0, v); chk("R7 rxd txd levels", v, 16'h1900);
    @(negedge clk); dsr_in = 0; rxd_in = 0; txd_lvl = 0; settle();
    bwr(3'd2, 8'hFF); settle();
    brd(3'd0, v); chk("R7 levels low", v, 16'h0000);

    // R9 rts control
    bwr(3'd4, 8'h01); settle();
    chk("R9 sw rts high", {15'd0, rts_out}, 16'd1);
    brd(3'd0, v); chk("R7 rts level shown", v, 16'h0400);
    @(negedge clk); rx_count = 4; rx_wmark = 4;
    bwr(3'd4, 8'h03); settle();
    chk("R9 hw rts at watermark", {15'd0, rts_out}, 16'd0);
    @(negedge clk); rx_count = 3; settle();
    chk("R9 hw rts below watermark", {15'd0, rts_out}, 16'd1);
    bwr(3'd4, 8'h02); settle();
    chk("R9 sw bit ignored in hw mode", {15'd0, rts_out}, 16'd1);
    @(negedge clk); rx_count = 5; settle();
    chk("R9 hw rts above watermark", {15'd0, rts_out}, 16'd0);
    bwr(3'd4, 8'h00);
    @(negedge clk); rx_count = 0; rx_wmark = 0; settle();
    bwr(3'd2, 8'hFF);

    // R10 event and clear in the same cycle
    @(negedge clk);
    err_parity = 1; bus_sel = 1; bus_wr = 1; bus_addr = 3'd2; bus_wdata = 8'h04;
    @(negedge clk);
    err_parity = 0; bus_sel = 0; bus_wr = 0;
    settle(); brd(3'd0, v); chk("R10 set wins over clear", v, 16'h0004);
    bwr(3'd2, 8'h04); settle(); brd(3'd0, v); chk("R4 later clear works", v, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule